// File: doc/BRIEF.md
# Prioritised Interrupt Request Controller

The block gathers eight interrupt request lines onto one interrupt output for a processor. It latches each rising request as pending and picks the lowest-numbered pending line that is not masked. It turns that line number into a vector and stores the vector where software can read it. It then raises the interrupt output and holds it until the processor writes an acknowledge. Only one interrupt is outstanding at a time. Masked requests are kept pending and are delivered once the mask bit clears.

Software uses a small register bus. It writes the per-line mask and the upper bits of the vector base, reads the latched vector, and acknowledges the interrupt. The vector is the base plus the line number, and the base resets to 32. For more inputs, a second identical unit can drive request line 2 of this one. That unit's output is a held level that produces one rising edge per interrupt, which gives 15 usable lines.

Top module: `intr_ctrl8`

## Requirements
- R1: After reset, the interrupt output is low, no line is pending, the mask reads 0x00, the base reads 32 (0x20) and the vector reads 0x00.
- R2: A request is latched as pending only on a rising edge of its input (low in one cycle, high in the next). A line that stays high produces one interrupt, not a stream.
- R3: When several unmasked lines are pending, the lowest-numbered line is served first.
- R4: The vector equals {base[7:3], n} for line n, which is base plus n. Writes to address 1 keep only bits 7:3, and bits 2:0 read back as zero.
- R5: Register reads are registered. The value for `addr_i` sampled at one edge appears on `rdata_o` after that edge. Address 0 reads the mask, 1 the base, 2 the vector and 3 reads zero.
- R6: The interrupt output rises on the edge after a pending unmasked line is seen. It stays high until an edge at which `wr_en_i` is high with `addr_i` = 3, and it is low after that edge.
- R7: While the interrupt output is high, new requests neither change the vector nor cause another assertion. They stay pending.
- R8: A line whose mask bit (address 0, bit n; 1 = masked) is set is never chosen. Its request stays pending and is served once the bit is cleared.
- R9: A write to address 3 while the interrupt output is low has no effect.
- R10: After an acknowledge, a request that is still pending raises the output again after exactly one low cycle.
- R11: The chosen line's pending bit is cleared when its vector is latched. A new rising edge on that line, even while it is being served, makes it pending again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_i | input | 8 | Request lines, line 0 has the highest priority |
| addr_i | input | 2 | Register address |
| wr_en_i | input | 1 | Register write strobe |
| wdata_i | input | 8 | Register write data |
| rdata_o | output | 8 | Registered read data |
| intr_o | output | 1 | Interrupt output to the processor |

## Verification
A wrong pending or mask bit shows up at the ports within two cycles. An interrupt appears for the wrong line, or fails to appear, and the vector read back names the wrong line. A stuck or missed acknowledge in the service state shows as an output that stays high, or one that drops, on the cycle after the write. A bad base register corrupts the next vector and every read of address 1. Comparing both outputs against a reference model on every clock catches each of these on the first cycle it differs.

// File: rtl/intr_ctrl_pkg.sv
package intr_ctrl_pkg;

  typedef enum logic {
    ST_WATCH = 1'b0,
    ST_SERVE = 1'b1
  } serve_state_t;

  localparam int unsigned REG_ADDR_W = 2;

  typedef enum logic [REG_ADDR_W-1:0] {
    A_MASK = 2'd0,
    A_BASE = 2'd1,
    A_VEC  = 2'd2,
    A_ACK  = 2'd3
  } reg_addr_t;

endpackage

// File: rtl/intr_edge_pending.sv
module intr_edge_pending #(
  parameter int unsigned N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] req_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o
);

  logic [N-1:0] prev_q;

  generate
    for (genvar g = 0; g < N; g++) begin : g_line
      logic rise;
      assign rise = req_i[g] & ~prev_q[g];

      always_ff @(posedge clk) begin
        if (rst) begin
          prev_q[g] <= 1'b0;
          pend_o[g] <= 1'b0;
        end else begin
          prev_q[g] <= req_i[g];
          pend_o[g] <= (pend_o[g] & ~clr_i[g]) | rise;
        end
      end
    end
  endgenerate

endmodule

// File: rtl/intr_lowest_pick.sv
module intr_lowest_pick #(
  parameter int unsigned N     = 8,
  parameter int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     cand_i,
  output logic             hit_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [N-1:0]     onehot_o
);

  always_comb begin
    idx_o    = '0;
    onehot_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (cand_i[i]) begin
        idx_o    = IDX_W'(i);
        onehot_o = N'(1) << i;
      end
    end
  end

  assign hit_o = |cand_i;

endmodule

// File: rtl/intr_bus_regs.sv
module intr_bus_regs
  import intr_ctrl_pkg::*;
#(
  parameter int unsigned N          = 8,
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned IDX_W      = 3,
  parameter int unsigned RESET_BASE = 32,
  localparam int unsigned BASE_HI_W = DATA_W - IDX_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [REG_ADDR_W-1:0] addr_i,
  input  logic                  wr_en_i,
  input  logic [DATA_W-1:0]     wdata_i,
  input  logic [DATA_W-1:0]     vec_i,
  output logic [N-1:0]          mask_o,
  output logic [BASE_HI_W-1:0]  base_o,
  output logic                  ack_o,
  output logic [DATA_W-1:0]     rdata_o
);

  localparam logic [BASE_HI_W-1:0] BASE_RST = BASE_HI_W'(RESET_BASE >> IDX_W);

  reg_addr_t sel;
  assign sel   = reg_addr_t'(addr_i);
  assign ack_o = wr_en_i && (sel == A_ACK);

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_o <= '0;
      base_o <= BASE_RST;
    end else if (wr_en_i) begin
      if (sel == A_MASK) mask_o <= wdata_i[N-1:0];
      if (sel == A_BASE) base_o <= wdata_i[DATA_W-1:IDX_W];
    end
  end

  logic [DATA_W-1:0] rd_mux;
  always_comb begin
    unique case (sel)
      A_MASK:  rd_mux = DATA_W'(mask_o);
      A_BASE:  rd_mux = {base_o, {IDX_W{1'b0}}};
      A_VEC:   rd_mux = vec_i;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_o <= '0;
    else     rdata_o <= rd_mux;
  end

endmodule

// File: rtl/intr_ctrl8.sv
module intr_ctrl8
  import intr_ctrl_pkg::*;
#(
  parameter int unsigned N          = 8,
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned RESET_BASE = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N-1:0]      irq_i,
  input  logic [1:0]        addr_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              intr_o
);

  localparam int unsigned IDX_W     = (N > 1) ? $clog2(N) : 1;
  localparam int unsigned BASE_HI_W = DATA_W - IDX_W;

  logic [N-1:0]           pend_q;
  logic [N-1:0]           mask_q;
  logic [N-1:0]           clr;
  logic [N-1:0]           pick_oh;
  logic [IDX_W-1:0]       pick_idx;
  logic                   pick_hit;
  logic [BASE_HI_W-1:0]   base_q;
  logic [DATA_W-1:0]      vec_q;
  logic                   ack;
  serve_state_t           state_q;

  intr_edge_pending #(.N(N)) u_pend (
    .clk    (clk),
    .rst    (rst),
    .req_i  (irq_i),
    .clr_i  (clr),
    .pend_o (pend_q)
  );

  intr_lowest_pick #(.N(N), .IDX_W(IDX_W)) u_pick (
    .cand_i   (pend_q & ~mask_q),
    .hit_o    (pick_hit),
    .idx_o    (pick_idx),
    .onehot_o (pick_oh)
  );

  intr_bus_regs #(
    .N(N), .DATA_W(DATA_W), .IDX_W(IDX_W), .RESET_BASE(RESET_BASE)
  ) u_regs (
    .clk     (clk),
    .rst     (rst),
    .addr_i  (addr_i),
    .wr_en_i (wr_en_i),
    .wdata_i (wdata_i),
    .vec_i   (vec_q),
    .mask_o  (mask_q),
    .base_o  (base_q),
    .ack_o   (ack),
    .rdata_o (rdata_o)
  );

  logic take;
  assign take = (state_q == ST_WATCH) && pick_hit;
  assign clr  = take ? pick_oh : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_WATCH;
      vec_q   <= '0;
    end else begin
      unique case (state_q)
        ST_WATCH: if (pick_hit) begin
          vec_q   <= {base_q, pick_idx};
          state_q <= ST_SERVE;
        end
        ST_SERVE: if (ack) state_q <= ST_WATCH;
        default:  state_q <= ST_WATCH;
      endcase
    end
  end

  assign intr_o = (state_q == ST_SERVE);

endmodule

// File: rtl/intr_ctrl8_chk.sv
module intr_ctrl8_chk #(
  parameter int unsigned N      = 8,
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              intr_o,
  input logic              wr_en_i,
  input logic [1:0]        addr_i,
  input logic [DATA_W-1:0] vec_q,
  input logic [N-1:0]      mask_q,
  input logic [N-1:0]      pend_q
);

  localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1;

  logic [N-1:0] mask_d, pend_d;
  always_ff @(posedge clk) begin
    if (rst) begin
      mask_d <= '0;
      pend_d <= '0;
    end else begin
      mask_d <= mask_q;
      pend_d <= pend_q;
    end
  end

  logic [IDX_W-1:0] lo;
  assign lo = vec_q[IDX_W-1:0];

  logic ackw;
  assign ackw = wr_en_i && (addr_i == 2'd3);

  assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (intr_o && !ackw) |=> intr_o);

  assert_ack_clears_R6: assert property (@(posedge clk) disable iff (rst)
    (intr_o && ackw) |=> !intr_o);

  assert_single_flight_R7: assert property (@(posedge clk) disable iff (rst)
    (intr_o && $past(intr_o)) |-> $stable(vec_q));

  assert_masked_skipped_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(intr_o) |-> !mask_d[lo]);

  assert_lowest_first_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(intr_o) |-> (pend_d[lo] && (((pend_d & ~mask_d) & ((N'(1) << lo) - N'(1))) == '0)));

endmodule

bind intr_ctrl8 intr_ctrl8_chk #(.N(N), .DATA_W(DATA_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .intr_o  (intr_o),
  .wr_en_i (wr_en_i),
  .addr_i  (addr_i),
  .vec_q   (vec_q),
  .mask_q  (mask_q),
  .pend_q  (pend_q)
);

// File: tb/intr_ctrl8_test.sv
`timescale 1ns/1ps
module intr_ctrl8_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] irq_i = '0;
  logic [1:0] addr_i = '0;
  logic       wr_en_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic       intr_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  intr_ctrl8 uut (
    .clk(clk), .rst(rst), .irq_i(irq_i), .addr_i(addr_i),
    .wr_en_i(wr_en_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .intr_o(intr_o)
  );

  // Behavioural reference model
  bit [7:0] m_prev, m_pend, m_mask, m_base, m_vec, m_rd;
  bit       m_intr;

  always @(posedge clk) begin
    bit [7:0] rise, clr, cand, rdn;
    if (rst) begin
      m_prev = 0; m_pend = 0; m_mask = 0; m_base = 8'd32;
      m_vec = 0; m_rd = 0; m_intr = 0;
    end else begin
      case (addr_i)
        2'd0: rdn = m_mask;
        2'd1: rdn = m_base;
        2'd2: rdn = m_vec;
        default: rdn = 0;
      endcase
      rise = irq_i & ~m_prev;
      clr  = 0;
      if (!m_intr) begin
        cand = m_pend & ~m_mask;
        for (int n = 7; n >= 0; n--)
          if (cand[n]) begin
            clr = 8'(1) << n;
            m_vec = m_base + 8'(n);
          end
        if (cand != 0) m_intr = 1;
      end else if (wr_en_i && addr_i == 2'd3) begin
        m_intr = 0;
      end
      m_pend = (m_pend & ~clr) | rise;
      m_prev = irq_i;
      if (wr_en_i && addr_i == 2'd0) m_mask = wdata_i;
      if (wr_en_i && addr_i == 2'd1) m_base = wdata_i & 8'hF8;
      m_rd = rdn;
    end
  end

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      check("R6 intr_o vs model", int'(intr_o), int'(m_intr));
      check("R5 rdata_o vs model", int'(rdata_o), int'(m_rd));
    end
  end

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    wr_en_i = 1; addr_i = a; wdata_i = d;
    tick();
    wr_en_i = 0; addr_i = 0;
  endtask

  task automatic rd(logic [1:0] a, string tag, int exp);
    addr_i = a;
    tick();
    check(tag, int'(rdata_o), exp);
    addr_i = 0;
  endtask

  task automatic pulse(logic [7:0] lines);
    irq_i = lines; tick(); irq_i = 0;
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    tick(4);
    rst = 0;
    check("R1 intr after reset", int'(intr_o), 0);
    rd(2'd0, "R1 mask reset", 8'h00);
    rd(2'd1, "R1 base reset", 8'h20);
    rd(2'd2, "R1 vector reset", 8'h00);
    tick(3);
    check("R1 nothing pending", int'(intr_o), 0);

    // R3 lowest first, R4 vector, R5 readback
    pulse(8'h28);
    tick();
    check("R6 intr raised", int'(intr_o), 1);
    rd(2'd2, "R3 lowest of 3,5", 35);
    // R7: request during service
    pulse(8'h02);
    tick(2);
    check("R7 still one in flight", int'(intr_o), 1);
    rd(2'd2, "R7 vector unchanged", 35);
    wr(2'd3, 8'h00);
    check("R6 ack clears", int'(intr_o), 0);
    tick();
    check("R10 re-raise after one low cycle", int'(intr_o), 1);
    rd(2'd2, "R3 line 1 before line 5", 33);
    wr(2'd3, 8'h00);
    tick();
    check("R10 line 5 next", int'(intr_o), 1);
    rd(2'd2, "R4 vector base+5", 37);
    wr(2'd3, 8'h00);
    tick(2);
    check("R6 idle after last ack", int'(intr_o), 0);

    // R9 idle ack
    wr(2'd3, 8'h00);
    tick();
    check("R9 idle ack no effect", int'(intr_o), 0);
    rd(2'd2, "R9 vector kept", 37);

    // R8 masking
    wr(2'd0, 8'h10);
    pulse(8'h10);
    tick(5);
    check("R8 masked line held", int'(intr_o), 0);
    rd(2'd0, "R8 mask readback", 8'h10);
    wr(2'd0, 8'h00);
    tick();
    check("R8 delivered on unmask", int'(intr_o), 1);
    rd(2'd2, "R8 vector of line 4", 36);
    wr(2'd3, 8'h00);

    // R4 base write
    wr(2'd1, 8'h47);
    rd(2'd1, "R4 base low bits dropped", 8'h40);
    pulse(8'h01);
    tick();
    rd(2'd2, "R4 new base vector", 8'h40);
    wr(2'd3, 8'h00);

    // R2 level held high
    irq_i = 8'h40;
    tick(2);
    check("R2 held line fires once", int'(intr_o), 1);
    wr(2'd3, 8'h00);
    tick(4);
    check("R2 no repeat while held", int'(intr_o), 0);

    // R11 re-edge during service
    irq_i = 0; tick();
    irq_i = 8'h40; tick(2);
    check("R11 fresh edge fires", int'(intr_o), 1);
    irq_i = 0; tick();
    irq_i = 8'h40; tick(2);
    wr(2'd3, 8'h00);
    tick();
    check("R11 re-latched during service", int'(intr_o), 1);
    rd(2'd2, "R11 same line vector", 8'h46);
    wr(2'd3, 8'h00);
    irq_i = 0;
    tick(2);

    // Mixed traffic against the model
    for (int c = 0; c < 4000; c++) begin
      irq_i   = 8'($urandom) & 8'($urandom) & 8'($urandom);
      addr_i  = 2'($urandom);
      wr_en_i = ($urandom % 4) == 0;
      wdata_i = 8'($urandom);
      if (addr_i == 2'd0) wdata_i = wdata_i & 8'($urandom);
      tick();
    end
    wr_en_i = 0;
    irq_i = 0;
    tick(2);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule